// File: doc/BRIEF.md
# Reloadable DMA Address Counter

This block supplies the running memory address for a DMA engine. Software sets a start address by writing its two 16-bit halves into two write-only registers at fixed IO offsets. Any write to either half also copies the complete start address, including the half just written, into the address counter on the same clock edge. This lets a new transfer begin without a separate "go" command.

While DMA is enabled, each transfer strobe advances the counter by one word. A two-bit mode field selects the operating mode. In display mode, each rising edge of the vertical retrace input reloads the counter from the start registers, so every frame scans the frame buffer again from its base. Memory access and video timing generation happen outside this block.

Top module: `dma_addr_counter`

## Requirements
- R1: After reset, the counter output and both start-address halves are zero.
- R2: A write to offset 0x4006 stores the data as the upper half of the start address. At that same clock edge, the counter takes {new upper half, stored lower half}.
- R3: A write to offset 0x4206 stores the data as the lower half of the start address. At that same clock edge, the counter takes {stored upper half, new lower half}.
- R4: A write to any other offset changes neither the counter nor either stored half.
- R5: With enable high and a transfer strobe, and no reload in that cycle, the counter grows by one at the next edge and wraps from 0xFFFFFFFF to 0.
- R6: With enable low or with no strobe, and no reload, the counter holds its value.
- R7: In display mode (mode field 2'b01), the counter reloads from the start registers at the edge where the retrace input is first sampled high. This does not depend on enable. Holding retrace high does not reload again.
- R8: In the modes 2'b00, 2'b10 and 2'b11, the retrace input has no effect.
- R9: A reload, from a write or from a retrace, overrides an increment requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ioWrite | input | 1 | IO write strobe |
| ioAddr | input | 16 | IO write offset |
| ioData | input | 16 | IO write data |
| modeSel | input | 2 | DMA mode field; 2'b01 is display mode |
| dmaEnable | input | 1 | Active-high DMA enable |
| xferStrobe | input | 1 | One pulse per transferred word |
| vRetrace | input | 1 | Vertical retrace level |
| addrOut | output | 32 | Current DMA address |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. A register write, a retrace rise or a strobe sampled at edge N shows on addrOut after edge N. The bench changes inputs on falling edges and compares addrOut on the next falling edge, so exactly one rising edge lies between stimulus and check. The bench runs a small reference model built from the requirements alongside the design. It sweeps every mode, enable, strobe and retrace combination, and it also exercises write collisions, foreign offsets and counter wrap.

// File: rtl/dma_ctr_pkg.sv
package dma_ctr_pkg;
  typedef struct packed {
    logic loadHi;      // store upper start half
    logic loadLo;      // store lower start half
    logic retraceLoad; // reload counter on retrace rise
    logic advance;     // step the counter
  } ctrlStrobes_t;
endpackage

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl
  import dma_ctr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 16'h4006,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 16'h4206,
  parameter logic [1:0] DISPLAY_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        modeSel,
  input  logic              dmaEnable,
  input  logic              xferStrobe,
  input  logic              vRetrace,
  output ctrlStrobes_t      strobes
);
  logic retracePrev;
  logic retraceRise;
  logic displayMode;
  logic anyLoad;

  always_ff @(posedge clk) begin
    if (!rstN) retracePrev <= 1'b0;
    else       retracePrev <= vRetrace;
  end

  assign retraceRise = vRetrace & ~retracePrev;
  assign displayMode = (modeSel == DISPLAY_CODE);

  always_comb begin
    strobes.loadHi      = ioWrite && (ioAddr == HI_OFFSET);
    strobes.loadLo      = ioWrite && (ioAddr == LO_OFFSET);
    strobes.retraceLoad = displayMode && retraceRise;
    anyLoad             = strobes.loadHi | strobes.loadLo | strobes.retraceLoad;
    strobes.advance     = dmaEnable && xferStrobe && !anyLoad;
  end

  // R7: a retrace reload can never fire on two consecutive edges
  assert_retrace_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retraceLoad |=> !strobes.retraceLoad);

  // R8: outside display mode the retrace never requests a reload
  assert_retrace_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != DISPLAY_CODE) |-> !strobes.retraceLoad);
endmodule

// File: rtl/dma_addr_path.sv
module dma_addr_path
  import dma_ctr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int STEP = 1,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [HALF_W-1:0] wrData,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [HALF_W-1:0] startHi, startLo;
  logic [HALF_W-1:0] nextHi, nextLo;
  logic reloadNow;

  always_comb begin
    nextHi    = strobes.loadHi ? wrData : startHi;
    nextLo    = strobes.loadLo ? wrData : startLo;
    reloadNow = strobes.loadHi | strobes.loadLo | strobes.retraceLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startHi <= '0;
      startLo <= '0;
    end else begin
      startHi <= nextHi;
      startLo <= nextLo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (reloadNow)       count <= {nextHi, nextLo};
    else if (strobes.advance) count <= count + STEP_V;
  end

  // R5: an advance strobe adds exactly one step
  assert_advance_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && strobes.advance |=> count == $past(count) + STEP_V);

  // R7: a retrace reload alone restores the stored start address
  assert_retrace_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retraceLoad && !strobes.loadHi && !strobes.loadLo
      |=> count == {$past(startHi), $past(startLo)});

  // R4: without a register write the start halves stay put
  assert_start_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !strobes.loadHi && !strobes.loadLo
      |=> $stable(startHi) && $stable(startLo));
endmodule

// File: rtl/dma_addr_counter.sv
module dma_addr_counter
  import dma_ctr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 16,
  parameter int STEP = 1,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 16'h4006,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 16'h4206,
  parameter logic [1:0] DISPLAY_CODE = 2'b01,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [HALF_W-1:0] ioData,
  input  logic [1:0]        modeSel,
  input  logic              dmaEnable,
  input  logic              xferStrobe,
  input  logic              vRetrace,
  output logic [CNT_W-1:0]  addrOut
);
  ctrlStrobes_t strobes;

  dma_addr_ctrl #(
    .ADDR_W(ADDR_W), .HI_OFFSET(HI_OFFSET), .LO_OFFSET(LO_OFFSET),
    .DISPLAY_CODE(DISPLAY_CODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .modeSel(modeSel), .dmaEnable(dmaEnable), .xferStrobe(xferStrobe),
    .vRetrace(vRetrace), .strobes(strobes)
  );

  dma_addr_path #(.HALF_W(HALF_W), .STEP(STEP)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(ioData),
    .count(addrOut)
  );

  // R2: upper-half write shows in the upper counter half next edge
  assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ioWrite && ioAddr == HI_OFFSET |=> addrOut[CNT_W-1:HALF_W] == $past(ioData));

  // R3: lower-half write shows in the lower counter half next edge
  assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    ioWrite && ioAddr == LO_OFFSET |=> addrOut[HALF_W-1:0] == $past(ioData));

  // R6, R9: idle counter holds when nothing requests a change
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !ioWrite && !vRetrace && !(dmaEnable && xferStrobe)
      |=> $stable(addrOut));
endmodule

// File: tb/test_dma_addr_counter.sv
`timescale 1ns/1ps
module test_dma_addr_counter;
  localparam logic [15:0] HI = 16'h4006;
  localparam logic [15:0] LO = 16'h4206;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWrite = 1'b0;
  logic [15:0] ioAddr = '0, ioData = '0;
  logic [1:0] modeSel = '0;
  logic dmaEnable = 1'b0, xferStrobe = 1'b0, vRetrace = 1'b0;
  logic [31:0] addrOut;

  int total = 0, bad = 0;
  logic [15:0] mHi = '0, mLo = '0;
  logic [31:0] mCnt = '0;
  logic mPrev = 1'b0;

  always #10 clk = ~clk;

  dma_addr_counter i_dma_addr_counter (
    .clk(clk), .rstN(rstN), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioData(ioData), .modeSel(modeSel), .dmaEnable(dmaEnable),
    .xferStrobe(xferStrobe), .vRetrace(vRetrace), .addrOut(addrOut)
  );

  task automatic check(input string tag, input logic [31:0] exp);
    total++;
    if (addrOut !== exp) begin
      bad++;
      $display("FAIL %s: addrOut=%h expected=%h", tag, addrOut, exp);
    end
  endtask

  // drive one cycle, update the model, check after the rising edge
  task automatic step(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [1:0] m, input logic en, input logic st,
                      input logic rt, input string tag);
    logic loaded, rise;
    ioWrite = wr; ioAddr = a; ioData = d; modeSel = m;
    dmaEnable = en; xferStrobe = st; vRetrace = rt;
    loaded = 1'b0;
    if (wr && a == HI) begin mHi = d; loaded = 1'b1; end
    if (wr && a == LO) begin mLo = d; loaded = 1'b1; end
    rise = rt && !mPrev;
    mPrev = rt;
    if (loaded || (m == 2'b01 && rise)) mCnt = {mHi, mLo};
    else if (en && st) mCnt = mCnt + 32'd1;
    @(negedge clk);
    check(tag, mCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: addrOut=%h expected=finish", addrOut);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", 32'h0);
    // R1: retrace reload right after reset yields the zero start address
    step(0, 0, 0, 2'b01, 0, 0, 1, "R1 start zero");
    step(0, 0, 0, 2'b01, 0, 0, 0, "R1 idle");
    // R2, R3: load start halves
    step(1, HI, 16'h1234, 2'b00, 0, 0, 0, "R2 hi write");
    step(1, LO, 16'h5678, 2'b00, 0, 0, 0, "R3 lo write");
    step(1, LO, 16'hFFF0, 2'b00, 0, 0, 0, "R3 lo rewrite");
    step(1, HI, 16'hA5A5, 2'b00, 0, 0, 0, "R2 hi rewrite");
    // R4: foreign offsets
    for (int k = 0; k < 8; k++) begin
      logic [15:0] fa;
      fa = (k < 4) ? (HI ^ (16'h1 << k)) : (LO ^ (16'h100 << k));
      step(1, fa, 16'hDEAD, 2'b00, 0, 0, 0, "R4 foreign offset");
    end
    step(0, 0, 0, 2'b01, 0, 0, 1, "R4 start regs kept");
    step(0, 0, 0, 2'b01, 0, 0, 0, "R4 idle");
    // sweep every mode, enable, strobe, retrace pattern (R5 R6 R7 R8)
    for (int m = 0; m < 4; m++) begin
      for (int en = 0; en < 2; en++) begin
        for (int st = 0; st < 2; st++) begin
          for (int rp = 0; rp < 4; rp++) begin
            for (int c = 0; c < 4; c++) begin
              logic rt;
              string tg;
              rt = rp[c % 2] ? 1'b1 : (rp == 3 && c > 1);
              if (m == 1 && rt) tg = "R7 display retrace";
              else if (rt) tg = "R8 retrace ignored";
              else if (en == 1 && st == 1) tg = "R5 advance";
              else tg = "R6 hold";
              step(0, 0, 0, 2'(m), en[0], st[0], rt, tg);
            end
          end
        end
      end
    end
    // R5: wrap
    step(1, HI, 16'hFFFF, 2'b00, 0, 0, 0, "R2 hi all ones");
    step(1, LO, 16'hFFFE, 2'b00, 0, 0, 0, "R3 lo near top");
    step(0, 0, 0, 2'b00, 1, 1, 0, "R5 to top");
    step(0, 0, 0, 2'b00, 1, 1, 0, "R5 wrap to zero");
    step(0, 0, 0, 2'b00, 1, 1, 0, "R5 after wrap");
    // R9: reload beats increment
    step(1, LO, 16'h0100, 2'b00, 1, 1, 0, "R9 write over advance");
    step(0, 0, 0, 2'b00, 1, 1, 0, "R5 advance after write");
    step(0, 0, 0, 2'b01, 1, 1, 1, "R9 retrace over advance");
    step(0, 0, 0, 2'b01, 1, 1, 1, "R7 held retrace advances");
    step(1, HI, 16'h0042, 2'b01, 1, 1, 0, "R9 hi write over advance");
    step(0, 0, 0, 2'b01, 1, 1, 0, "R5 advance");
    step(1, LO, 16'h0777, 2'b01, 1, 1, 1, "R9 write with retrace");
    step(0, 0, 0, 2'b01, 0, 0, 0, "R6 idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule